// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Unit

This block is the hazard and bypass controller of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback), with a latch between each pair of stages. It reads decoded fields from those latches and works out four things in the same cycle. The first is whether the decode-stage instruction has to wait one cycle for a load that is ahead of it. The second is which source feeds each execute operand. The third is whether a store in the memory stage takes its data from the writeback latch. The fourth is which wrong-path instructions a taken branch squashes.

A load-use conflict raises a hold, which freezes the PC and the fetch/decode latch, together with a bubble, which loads a nop into the decode/execute latch behind the load. A store's data operand never causes this hold: the load's value is bypassed into the memory stage one cycle later instead. Branch redirection has two modes. In the normal mode the branch resolves in execute and squashes both younger instructions. In the fast mode the branch resolves in decode and squashes only the instruction behind it. The datapath uses the flush outputs to clear the register-write and memory-write enables of the squashed latches, so they become nops. Register 0 always reads as zero.

The unit is purely combinational. Its outputs depend only on the current latch fields.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: `stall_hold` and `dx_bubble` are both 1 when the execute-stage instruction is a load (op code 01) with `dx_we`=1 and a nonzero `dx_rd` that equals `fd_rs1`.
- R2: A nonzero load destination that equals only `fd_rs2` raises the hold and bubble, except when `fd_op` is a store (op code 10). In that case both stay 0.
- R3: A load destination of register 0, or `dx_we`=0, never raises the hold or bubble. A source or destination of register 0 never selects a bypass path.
- R4: An execute operand select (`byp_a` for `dx_rs1`, `byp_b` for `dx_rs2`) is 01 (from the execute/memory latch) when `xm_we`=1, `xm_rd` is nonzero and equals that source, and `xm_op` is not a load.
- R5: When R4 does not apply, the select is 10 (from the memory/writeback latch) if `mw_we`=1 and `mw_rd` is nonzero and equals the source. Otherwise it is 00 (register file).
- R6: When both the execute/memory and memory/writeback latches qualify for the same source, the execute/memory latch wins (select 01).
- R7: `byp_store_data` is 1 exactly when `xm_op` is a store, `mw_we`=1, and `mw_rd` is nonzero and equals `xm_rs2`.
- R8: In normal mode (`fast_branch`=0), `branch_taken`=1 drives both `flush_fd` and `flush_dx` to 1.
- R9: In fast mode (`fast_branch`=1), `branch_taken`=1 drives only `flush_fd`, and only when no hold is raised in that cycle. `flush_dx` stays 0 in fast mode.
- R10: With `branch_taken`=0 both flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_branch | input | 1 | 1 = branch resolves in decode (one-instruction squash) |
| branch_taken | input | 1 | resolved branch is taken this cycle |
| fd_op | input | 2 | decode-stage op class: 00 ALU, 01 load, 10 store, 11 branch |
| fd_rs1 | input | REG_W | decode-stage first source |
| fd_rs2 | input | REG_W | decode-stage second source |
| dx_op | input | 2 | execute-stage op class |
| dx_rd | input | REG_W | execute-stage destination |
| dx_we | input | 1 | execute-stage register-write enable |
| dx_rs1 | input | REG_W | execute-stage first source |
| dx_rs2 | input | REG_W | execute-stage second source |
| xm_op | input | 2 | memory-stage op class |
| xm_rd | input | REG_W | memory-stage destination |
| xm_we | input | 1 | memory-stage register-write enable |
| xm_rs2 | input | REG_W | memory-stage store-data source |
| mw_rd | input | REG_W | writeback-stage destination |
| mw_we | input | 1 | writeback-stage register-write enable |
| stall_hold | output | 1 | hold PC and fetch/decode latch |
| dx_bubble | output | 1 | load a nop into decode/execute latch |
| flush_fd | output | 1 | squash fetch/decode latch contents |
| flush_dx | output | 1 | squash decode/execute latch contents |
| byp_a | output | 2 | first execute operand source: 00 RF, 01 X/M, 10 M/W |
| byp_b | output | 2 | second execute operand source, same coding |
| byp_store_data | output | 1 | memory-stage store data from M/W |

## Verification
The checks assume that the latch fields are well formed. A taken branch in normal mode has a branch in execute, so no load-use conflict can occur in the same cycle. A load in the execute/memory latch never needs its value forwarded into execute, except as a store's data. The stimulus keeps every field at a defined value and draws register numbers from a small range, so that register 0 and matching sources are hit often. The bench compares every output against a behavioural model in each cycle, so random field combinations that a real pipeline would not produce still have one defined answer.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam logic [1:0] OP_ALU    = 2'b00;
    localparam logic [1:0] OP_LOAD   = 2'b01;
    localparam logic [1:0] OP_STORE  = 2'b10;
    localparam logic [1:0] OP_BRANCH = 2'b11;

    typedef enum logic [1:0] {
        SRC_RF = 2'b00,
        SRC_XM = 2'b01,
        SRC_MW = 2'b10
    } byp_src_e;

endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [1:0]       fd_op,
    input  logic [REG_W-1:0] fd_rs1,
    input  logic [REG_W-1:0] fd_rs2,
    input  logic [1:0]       dx_op,
    input  logic [REG_W-1:0] dx_rd,
    input  logic             dx_we,
    output logic             hold
);
    logic load_live;
    logic hit_first;
    logic hit_second;

    always_comb begin
        load_live  = (dx_op == OP_LOAD) && dx_we && (dx_rd != '0);
        hit_first  = (dx_rd == fd_rs1);
        hit_second = (dx_rd == fd_rs2) && (fd_op != OP_STORE);
        hold       = load_live && (hit_first || hit_second);
    end
endmodule

// File: rtl/hz_byp_sel.sv
module hz_byp_sel
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] xm_rd,
    input  logic             xm_we,
    input  logic             xm_is_load,
    input  logic [REG_W-1:0] mw_rd,
    input  logic             mw_we,
    output byp_src_e         sel
);
    logic xm_hit;
    logic mw_hit;

    always_comb begin
        xm_hit = xm_we && !xm_is_load && (xm_rd != '0) && (xm_rd == src);
        mw_hit = mw_we && (mw_rd != '0) && (mw_rd == src);
        unique case ({xm_hit, mw_hit})
            2'b10, 2'b11: sel = SRC_XM;
            2'b01:        sel = SRC_MW;
            default:      sel = SRC_RF;
        endcase
    end
endmodule

// File: rtl/hz_flush.sv
module hz_flush (
    input  logic fast_mode,
    input  logic taken,
    input  logic hold,
    output logic squash_fd,
    output logic squash_dx
);
    always_comb begin
        unique case (fast_mode)
            1'b1: begin
                squash_fd = taken && !hold;
                squash_dx = 1'b0;
            end
            default: begin
                squash_fd = taken;
                squash_dx = taken;
            end
        endcase
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             fast_branch,
    input  logic             branch_taken,
    input  logic [1:0]       fd_op,
    input  logic [REG_W-1:0] fd_rs1,
    input  logic [REG_W-1:0] fd_rs2,
    input  logic [1:0]       dx_op,
    input  logic [REG_W-1:0] dx_rd,
    input  logic             dx_we,
    input  logic [REG_W-1:0] dx_rs1,
    input  logic [REG_W-1:0] dx_rs2,
    input  logic [1:0]       xm_op,
    input  logic [REG_W-1:0] xm_rd,
    input  logic             xm_we,
    input  logic [REG_W-1:0] xm_rs2,
    input  logic [REG_W-1:0] mw_rd,
    input  logic             mw_we,
    output logic             stall_hold,
    output logic             dx_bubble,
    output logic             flush_fd,
    output logic             flush_dx,
    output logic [1:0]       byp_a,
    output logic [1:0]       byp_b,
    output logic             byp_store_data
);
    localparam int N_OPND = 2;

    logic                   hold_w;
    logic                   xm_is_load;
    logic [REG_W-1:0]       opnd_src [N_OPND];
    byp_src_e               opnd_sel [N_OPND];

    assign xm_is_load  = (xm_op == OP_LOAD);
    assign opnd_src[0] = dx_rs1;
    assign opnd_src[1] = dx_rs2;

    hz_loaduse #(.REG_W(REG_W)) u_lu (
        .fd_op  (fd_op),
        .fd_rs1 (fd_rs1),
        .fd_rs2 (fd_rs2),
        .dx_op  (dx_op),
        .dx_rd  (dx_rd),
        .dx_we  (dx_we),
        .hold   (hold_w)
    );

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hz_byp_sel #(.REG_W(REG_W)) u_sel (
            .src        (opnd_src[g]),
            .xm_rd      (xm_rd),
            .xm_we      (xm_we),
            .xm_is_load (xm_is_load),
            .mw_rd      (mw_rd),
            .mw_we      (mw_we),
            .sel        (opnd_sel[g])
        );
    end

    hz_flush u_fl (
        .fast_mode (fast_branch),
        .taken     (branch_taken),
        .hold      (hold_w),
        .squash_fd (flush_fd),
        .squash_dx (flush_dx)
    );

    always_comb begin
        stall_hold     = hold_w;
        dx_bubble      = hold_w;
        byp_a          = opnd_sel[0];
        byp_b          = opnd_sel[1];
        byp_store_data = (xm_op == OP_STORE) && mw_we && (mw_rd != '0)
                         && (mw_rd == xm_rs2);
    end
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input logic             fast_branch,
    input logic             branch_taken,
    input logic [1:0]       fd_op,
    input logic [REG_W-1:0] fd_rs1,
    input logic [REG_W-1:0] fd_rs2,
    input logic [1:0]       dx_op,
    input logic [REG_W-1:0] dx_rd,
    input logic             dx_we,
    input logic [REG_W-1:0] dx_rs1,
    input logic [1:0]       xm_op,
    input logic [REG_W-1:0] xm_rd,
    input logic             xm_we,
    input logic [REG_W-1:0] mw_rd,
    input logic             mw_we,
    input logic             stall_hold,
    input logic             dx_bubble,
    input logic             flush_fd,
    input logic             flush_dx,
    input logic [1:0]       byp_a
);
    always_comb begin
        if (!$isunknown({fast_branch, branch_taken, fd_op, fd_rs1, fd_rs2, dx_op, dx_rd,
                         dx_we, dx_rs1, xm_op, xm_rd, xm_we, mw_rd, mw_we})) begin
            AST_HOLD_NEEDS_LOAD: assert (!stall_hold || (dx_op == OP_LOAD && dx_we && dx_rd != '0))
                else $error("hold without a live load"); // R1
            AST_BUBBLE_TRACKS_HOLD: assert (stall_hold == dx_bubble)
                else $error("hold and bubble disagree"); // R1
            AST_STORE_DATA_EXEMPT: assert (!(fd_op == OP_STORE && dx_rd == fd_rs2 && dx_rd != fd_rs1) || !stall_hold)
                else $error("store data operand stalled"); // R2
            AST_ZERO_NO_BYPASS: assert (dx_rs1 != '0 || byp_a == 2'b00)
                else $error("register 0 bypassed"); // R3
            AST_XM_WINS: assert (!(xm_we && xm_op != OP_LOAD && xm_rd != '0 && xm_rd == dx_rs1) || byp_a == 2'b01)
                else $error("younger result lost priority"); // R6
            AST_FAST_SINGLE_FLUSH: assert (!fast_branch || !flush_dx)
                else $error("fast mode squashed two"); // R9
            AST_FAST_NO_FLUSH_ON_HOLD: assert (!(fast_branch && stall_hold) || !flush_fd)
                else $error("fast flush during hold"); // R9
            AST_NO_FLUSH_IDLE: assert (branch_taken || (!flush_fd && !flush_dx))
                else $error("flush without taken branch"); // R10
        end
    end
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_W(REG_W)) u_chk (
    .fast_branch  (fast_branch),
    .branch_taken (branch_taken),
    .fd_op        (fd_op),
    .fd_rs1       (fd_rs1),
    .fd_rs2       (fd_rs2),
    .dx_op        (dx_op),
    .dx_rd        (dx_rd),
    .dx_we        (dx_we),
    .dx_rs1       (dx_rs1),
    .xm_op        (xm_op),
    .xm_rd        (xm_rd),
    .xm_we        (xm_we),
    .mw_rd        (mw_rd),
    .mw_we        (mw_we),
    .stall_hold   (stall_hold),
    .dx_bubble    (dx_bubble),
    .flush_fd     (flush_fd),
    .flush_dx     (flush_dx),
    .byp_a        (byp_a)
);

// File: tb/sim_pipe_hazard_ctl.sv
module sim_pipe_hazard_ctl;
    localparam int RW = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          fast_branch, branch_taken, dx_we, xm_we, mw_we;
    logic [1:0]    fd_op, dx_op, xm_op;
    logic [RW-1:0] fd_rs1, fd_rs2, dx_rd, dx_rs1, dx_rs2, xm_rd, xm_rs2, mw_rd;
    logic          stall_hold, dx_bubble, flush_fd, flush_dx, byp_store_data;
    logic [1:0]    byp_a, byp_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    pipe_hazard_ctl #(.REG_W(RW)) u0 (
        .fast_branch(fast_branch), .branch_taken(branch_taken),
        .fd_op(fd_op), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2),
        .dx_op(dx_op), .dx_rd(dx_rd), .dx_we(dx_we), .dx_rs1(dx_rs1), .dx_rs2(dx_rs2),
        .xm_op(xm_op), .xm_rd(xm_rd), .xm_we(xm_we), .xm_rs2(xm_rs2),
        .mw_rd(mw_rd), .mw_we(mw_we),
        .stall_hold(stall_hold), .dx_bubble(dx_bubble),
        .flush_fd(flush_fd), .flush_dx(flush_dx),
        .byp_a(byp_a), .byp_b(byp_b), .byp_store_data(byp_store_data)
    );

    function automatic int src_of(int s);
        if (xm_we && xm_op != 2'b01 && xm_rd != 0 && int'(xm_rd) == s) return 1;
        if (mw_we && mw_rd != 0 && int'(mw_rd) == s) return 2;
        return 0;
    endfunction

    task automatic clear_all();
        {fast_branch, branch_taken, dx_we, xm_we, mw_we} = '0;
        {fd_op, dx_op, xm_op} = '0;
        {fd_rs1, fd_rs2, dx_rd, dx_rs1, dx_rs2, xm_rd, xm_rs2, mw_rd} = '0;
    endtask

    task automatic step(string tag);
        int  e_hold, e_fd, e_dx, e_a, e_b, e_sd;
        @(negedge clk);
        e_hold = 0;
        if (dx_op == 2'b01 && dx_we && dx_rd != 0) begin
            if (dx_rd == fd_rs1) e_hold = 1;
            if (dx_rd == fd_rs2 && fd_op != 2'b10) e_hold = 1;
        end
        e_a = src_of(int'(dx_rs1));
        e_b = src_of(int'(dx_rs2));
        e_sd = (xm_op == 2'b10 && mw_we && mw_rd != 0 && mw_rd == xm_rs2) ? 1 : 0;
        if (!branch_taken) begin e_fd = 0; e_dx = 0; end
        else if (fast_branch) begin e_fd = (e_hold != 0) ? 0 : 1; e_dx = 0; end
        else begin e_fd = 1; e_dx = 1; end
        n_chk++;
        if (int'(stall_hold) != e_hold || int'(dx_bubble) != e_hold || int'(flush_fd) != e_fd ||
            int'(flush_dx) != e_dx || int'(byp_a) != e_a || int'(byp_b) != e_b ||
            int'(byp_store_data) != e_sd) begin
            n_bad++;
            $display("FAIL %s: got hold=%0d bub=%0d ffd=%0d fdx=%0d a=%0d b=%0d sd=%0d exp hold=%0d bub=%0d ffd=%0d fdx=%0d a=%0d b=%0d sd=%0d",
                     tag, stall_hold, dx_bubble, flush_fd, flush_dx, byp_a, byp_b, byp_store_data,
                     e_hold, e_hold, e_fd, e_dx, e_a, e_b, e_sd);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        clear_all();
        step("reset state R3 R10");
        // R1: load rd=3 feeds decode rs1
        dx_op = 2'b01; dx_we = 1; dx_rd = 3; fd_rs1 = 3; fd_rs2 = 7;
        step("R1 load-use first source");
        // R2: second source, ALU consumer stalls
        fd_rs1 = 5; fd_rs2 = 3; fd_op = 2'b00;
        step("R2 load-use second source");
        // R2: store data exempt
        fd_op = 2'b10;
        step("R2 store data exempt");
        // R3: destination 0 and write disabled
        fd_rs1 = 0; dx_rd = 0;
        step("R3 load to r0 no hold");
        dx_rd = 3; fd_rs1 = 3; dx_we = 0;
        step("R3 write disabled no hold");
        clear_all();
        // R4: X/M forward both operands
        xm_op = 2'b00; xm_we = 1; xm_rd = 4; dx_rs1 = 4; dx_rs2 = 4;
        step("R4 forward from X/M");
        // R4: load in X/M not forwarded into execute
        xm_op = 2'b01;
        step("R4 no X/M load forward");
        // R5 and R6
        xm_op = 2'b00; mw_we = 1; mw_rd = 4; dx_rs2 = 9; xm_rd = 9;
        step("R5 R6 mixed sources");
        xm_rd = 4;
        step("R6 X/M wins");
        dx_rs1 = 0; dx_rs2 = 0; xm_rd = 0; mw_rd = 0;
        step("R3 r0 never bypassed");
        clear_all();
        // R7: store data from M/W
        xm_op = 2'b10; xm_rs2 = 6; mw_we = 1; mw_rd = 6;
        step("R7 store data bypass");
        mw_rd = 2;
        step("R7 no match");
        clear_all();
        // R8 / R9 / R10
        branch_taken = 1;
        step("R8 normal flush two");
        fast_branch = 1;
        step("R9 fast flush one");
        dx_op = 2'b01; dx_we = 1; dx_rd = 2; fd_rs1 = 2;
        step("R9 fast flush withheld on hold");
        branch_taken = 0;
        step("R10 no taken no flush");
        // random sweep
        for (int i = 0; i < 3000; i++) begin
            fast_branch  = 1'($urandom_range(0, 1));
            branch_taken = 1'($urandom_range(0, 1));
            fd_op  = 2'($urandom_range(0, 3));
            dx_op  = 2'($urandom_range(0, 3));
            xm_op  = 2'($urandom_range(0, 3));
            dx_we  = 1'($urandom_range(0, 1));
            xm_we  = 1'($urandom_range(0, 1));
            mw_we  = 1'($urandom_range(0, 1));
            fd_rs1 = RW'($urandom_range(0, 3));
            fd_rs2 = RW'($urandom_range(0, 3));
            dx_rd  = RW'($urandom_range(0, 3));
            dx_rs1 = RW'($urandom_range(0, 3));
            dx_rs2 = RW'($urandom_range(0, 3));
            xm_rd  = RW'($urandom_range(0, 3));
            xm_rs2 = RW'($urandom_range(0, 3));
            mw_rd  = RW'($urandom_range(0, 3));
            step("random R1 R2 R3 R4 R5 R6 R7 R8 R9 R10");
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        finish_run();
    end
endmodule